// File: doc/BRIEF.md
# SPI Byte-Addressed Configuration Register Port

This block is the serial front end of a small bank of 16-bit configuration registers. An SPI master in mode 3 (clock idle high, data driven on the falling edge and sampled on the rising edge) sends 16-bit frames. Each register spans two byte addresses: the even address holds the low byte and the odd address holds the high byte. A write frame therefore changes one byte of one register, and a full 16-bit update takes two frames.

A frame whose top bit is clear is a read request. The register that contains the addressed byte is captured when that frame ends and is shifted out most significant bit first during the next frame. All SPI pins are sampled through synchronizers in the system clock domain. Frames are judged only when chip select rises. A frame whose clock count is wrong, or that arrives while the `busy` input is high, is dropped entirely. Accepted writes also appear on a one-cycle register-bank write port.

The example bank holds four registers at byte addresses 0x44/0x45 (general I/O control, default 0x0000), 0x46/0x47 (miscellaneous control, default 0x0006), 0x48/0x49 (sample period, default 0x001F) and 0x4A/0x4B (command, default 0x0000).

Top module: `spi_byte_regport`

## Requirements
- R1: After reset the registers hold their defaults: `reg_words` = 0x0000_001F_0006_0000, with the register at 0x4A in bits 63:48 and the one at 0x44 in bits 15:0. `bank_we` and `spi_miso` are low.
- R2: A write frame has bit 15 = 1, the byte address in bits 14:8 and the data in bits 7:0. An odd address replaces bits 15:8 of the register at word address[6:1], an even address replaces bits 7:0, and the other byte keeps its value. Without a write strobe, no register changes.
- R3: A frame is committed only if exactly 16 rising SCLK edges occur while CS_n is low. With 15 or 17 edges, nothing is written and no read is armed.
- R4: If `busy` is high in any clock cycle from the detected fall of CS_n up to and including the commit cycle, the frame is dropped like an invalid one.
- R5: A write to a byte address outside the bank changes no register, although it still strobes the write port. A read of an unmapped address returns 0x0000.
- R6: A read frame (bit 15 = 0) returns the whole register of the addressed byte (odd or even address alike) during the next frame. The data comes MSB first and each bit is valid before its rising SCLK edge, with bit 15 valid before the first one.
- R7: Read data is captured in the commit cycle of the read frame. A write to the same register in the next frame does not alter the bits being shifted out. It takes effect at its own commit.
- R8: `spi_miso` is low whenever CS_n is high. The frame that follows any frame other than an accepted read shifts out all zeros.
- R9: An accepted write frame pulses `bank_we` for exactly one clock, in the third clock cycle after CS_n rises. `bank_addr` and `bank_byte` carry the frame's address and data. The register changes one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial read data to the master, low while deselected |
| busy | input | 1 | Suspension input; frames overlapping it are dropped |
| bank_we | output | 1 | One-cycle strobe for an accepted write frame |
| bank_addr | output | 7 | Byte address of the accepted write |
| bank_byte | output | 8 | Data byte of the accepted write |
| reg_words | output | NUM_REGS*16 | Current register contents, lowest address in the lowest bits |

## Verification
Two things can land in the same clock: the commit of a frame when CS_n rises, and `busy` going high. The bench raises `busy` for exactly the one cycle in which the synchronized chip select rises. It then checks on every clock that no strobe appears and no register moves. A second collision is a read response shifted out while the frame coming in rewrites that same register. Here the readback must show the old value, and the per-clock comparison must show the new value four cycles after CS_n rises. A behavioural model holding queued, cycle-stamped updates judges both cases.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int FRAME_W    = 16;
  localparam int ADDR_W     = 7;
  localparam int BYTE_W     = 8;
  localparam int REG_W      = 2 * BYTE_W;
  localparam int WORD_IDX_W = ADDR_W - 1;

  typedef struct packed {
    logic              is_write;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } frame_t;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_WRITE,
    ACT_READ,
    ACT_DROP
  } frame_act_e;

  // Split a received 16-bit word into its fields.
  function automatic frame_t split_frame(input logic [FRAME_W-1:0] w);
    return frame_t'(w);
  endfunction

  // Word (register) index of a byte address.
  function automatic logic [WORD_IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:1];
  endfunction

  // Replace one half of a register, leaving the other half intact.
  function automatic logic [REG_W-1:0] merge_byte(input logic [REG_W-1:0] old,
                                                  input logic             hi,
                                                  input logic [BYTE_W-1:0] b);
    return hi ? {b, old[BYTE_W-1:0]} : {old[REG_W-1:BYTE_W], b};
  endfunction

  // Decide what a frame boundary means.
  function automatic frame_act_e classify(input logic ended,
                                          input logic ok,
                                          input logic blocked,
                                          input logic is_wr);
    if (!ended)         return ACT_NONE;
    if (!ok || blocked) return ACT_DROP;
    return is_wr ? ACT_WRITE : ACT_READ;
  endfunction
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= RESET_VAL;
      else        pipe <= d;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RESET_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sbr_spi_front.sv
module sbr_spi_front
  import sbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               frame_start,
  output logic               frame_end,
  output logic               frame_ok,
  output logic               cs_active,
  output logic [FRAME_W-1:0] frame_word,
  output logic               spi_miso
);
  localparam int               CNT_W    = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic sclk_s, cs_s, mosi_s;
  logic sclk_q, cs_q;
  logic sclk_rise, sclk_fall;
  logic [CNT_W-1:0]   rx_cnt;
  logic [FRAME_W-1:0] rx_sh;
  logic [FRAME_W-1:0] tx_sh;
  logic               tx_skip;

  sbr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s));
  sbr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(spi_cs_n), .q(cs_s));
  sbr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  assign cs_active   = ~cs_s;
  assign frame_start = cs_q & ~cs_s;
  assign frame_end   = ~cs_q & cs_s;
  assign sclk_rise   = cs_active & sclk_s & ~sclk_q;
  assign sclk_fall   = cs_active & ~sclk_s & sclk_q;

  // Receive side: count rising edges (saturating one past a full frame).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt <= '0;
      rx_sh  <= '0;
    end else if (frame_start) begin
      rx_cnt <= '0;
    end else if (sclk_rise) begin
      rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
      if (rx_cnt != CNT_SAT) rx_cnt <= rx_cnt + 1'b1;
    end
  end

  assign frame_ok   = (rx_cnt == CNT_FULL);
  assign frame_word = rx_sh;

  // Transmit side: MSB presented at selection, advance on falling edges
  // after the first one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_skip <= 1'b1;
    end else if (frame_start) begin
      tx_sh   <= tx_word;
      tx_skip <= 1'b1;
    end else if (frame_end) begin
      tx_sh   <= '0;
    end else if (sclk_fall) begin
      if (tx_skip) tx_skip <= 1'b0;
      else         tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
    end
  end

  assign spi_miso = ~spi_cs_n & tx_sh[FRAME_W-1];
endmodule

// File: rtl/sbr_frame_ctl.sv
module sbr_frame_ctl
  import sbr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  frame_end,
  input  logic                  frame_ok,
  input  logic                  cs_active,
  input  logic                  busy,
  input  logic [FRAME_W-1:0]    frame_word,
  input  logic [REG_W-1:0]      rd_data,
  output logic [WORD_IDX_W-1:0] rd_word,
  output logic                  busy_seen,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [BYTE_W-1:0]     wr_byte,
  output logic [FRAME_W-1:0]    tx_word
);
  frame_t     fr;
  frame_act_e act;

  assign fr      = split_frame(frame_word);
  assign rd_word = word_of(fr.addr);
  assign act     = classify(frame_end, frame_ok, busy_seen | busy, fr.is_write);

  // Sticky suspension flag for the frame in progress.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_seen <= 1'b0;
    else if (frame_start)      busy_seen <= busy;
    else if (cs_active & busy) busy_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_byte <= '0;
      tx_word <= '0;
    end else begin
      wr_en <= 1'b0;
      unique case (act)
        ACT_WRITE: begin
          wr_en   <= 1'b1;
          wr_addr <= fr.addr;
          wr_byte <= fr.data;
          tx_word <= '0;
        end
        ACT_READ:  tx_word <= rd_data;
        ACT_DROP:  tx_word <= '0;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/sbr_reg_bank.sv
module sbr_reg_bank
  import sbr_pkg::*;
#(
  parameter int                      NUM_REGS  = 4,
  parameter int                      BASE_WORD = 34,
  parameter logic [NUM_REGS*16-1:0]  DEFAULTS  = {16'h0000, 16'h001F, 16'h0006, 16'h0000}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [BYTE_W-1:0]         wr_byte,
  input  logic [WORD_IDX_W-1:0]     rd_word,
  output logic [REG_W-1:0]          rd_data,
  output logic [NUM_REGS*REG_W-1:0] reg_words
);
  logic [REG_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [WORD_IDX_W-1:0] SLOT = WORD_IDX_W'(BASE_WORD + g);
    logic hit;
    assign hit = wr_en && (word_of(wr_addr) == SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= DEFAULTS[g*REG_W +: REG_W];
      else if (hit) regs[g] <= merge_byte(regs[g], wr_addr[0], wr_byte);
    end

    assign reg_words[g*REG_W +: REG_W] = regs[g];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_word == WORD_IDX_W'(BASE_WORD + k)) rd_data = regs[k];
    end
  end
endmodule

// File: rtl/spi_byte_regport.sv
module spi_byte_regport
  import sbr_pkg::*;
#(
  parameter int                     NUM_REGS    = 4,
  parameter int                     BASE_WORD   = 34,
  parameter logic [NUM_REGS*16-1:0] DEFAULTS    = {16'h0000, 16'h001F, 16'h0006, 16'h0000},
  parameter int                     SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sclk,
  input  logic                   spi_cs_n,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  input  logic                   busy,
  output logic                   bank_we,
  output logic [ADDR_W-1:0]      bank_addr,
  output logic [BYTE_W-1:0]      bank_byte,
  output logic [NUM_REGS*16-1:0] reg_words
);
  // Named internal events, also observed by the bound checker.
  logic                  frame_start;
  logic                  frame_end;
  logic                  frame_ok;
  logic                  cs_active;
  logic                  busy_seen;
  logic [FRAME_W-1:0]    frame_word;
  logic [FRAME_W-1:0]    tx_word;
  logic [REG_W-1:0]      rd_data;
  logic [WORD_IDX_W-1:0] rd_word;

  sbr_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi),
    .tx_word     (tx_word),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_ok    (frame_ok),
    .cs_active   (cs_active),
    .frame_word  (frame_word),
    .spi_miso    (spi_miso)
  );

  sbr_frame_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_ok    (frame_ok),
    .cs_active   (cs_active),
    .busy        (busy),
    .frame_word  (frame_word),
    .rd_data     (rd_data),
    .rd_word     (rd_word),
    .busy_seen   (busy_seen),
    .wr_en       (bank_we),
    .wr_addr     (bank_addr),
    .wr_byte     (bank_byte),
    .tx_word     (tx_word)
  );

  sbr_reg_bank #(
    .NUM_REGS  (NUM_REGS),
    .BASE_WORD (BASE_WORD),
    .DEFAULTS  (DEFAULTS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bank_we),
    .wr_addr   (bank_addr),
    .wr_byte   (bank_byte),
    .rd_word   (rd_word),
    .rd_data   (rd_data),
    .reg_words (reg_words)
  );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int NUM_REGS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_end,
  input logic                   frame_ok,
  input logic                   busy_seen,
  input logic                   bank_we,
  input logic                   bank_hi,
  input logic [NUM_REGS*16-1:0] reg_words
);
  // R9
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> !bank_we);

  // R2
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(reg_words));

  // R3
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_ok) |=> !bank_we);

  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && busy_seen) |=> !bank_we);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_half
    // R2
    lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_we && bank_hi) |=> (reg_words[g*16 +: 8] == $past(reg_words[g*16 +: 8])));
    // R2
    hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_we && !bank_hi) |=> (reg_words[g*16+8 +: 8] == $past(reg_words[g*16+8 +: 8])));
  end
endmodule

bind spi_byte_regport sbr_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_end (frame_end),
  .frame_ok  (frame_ok),
  .busy_seen (busy_seen),
  .bank_we   (bank_we),
  .bank_hi   (bank_addr[0]),
  .reg_words (reg_words)
);

// File: tb/test_spi_byte_regport.sv
module test_spi_byte_regport;
  localparam int HALF = 4;
  localparam int NREG = 4;
  localparam int BASE = 'h22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b1;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic busy = 1'b0;
  wire        spi_miso;
  wire        bank_we;
  wire [6:0]  bank_addr;
  wire [7:0]  bank_byte;
  wire [63:0] reg_words;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit monitor_on = 1'b0;

  logic [15:0] mreg [NREG];
  logic [15:0] exp_tx = 16'h0000;
  int          q_due[$];
  int          q_idx[$];
  bit          q_hi[$];
  logic [7:0]  q_byte[$];
  int          w_due[$];
  logic [6:0]  w_addr[$];
  logic [7:0]  w_byte[$];

  spi_byte_regport i_spi_byte_regport (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso),
    .busy      (busy),
    .bank_we   (bank_we),
    .bank_addr (bank_addr),
    .bank_byte (bank_byte),
    .reg_words (reg_words)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the queued model.
  always begin
    @(negedge clk);
    #2;
    if (monitor_on) begin
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
        if (q_hi[0]) mreg[q_idx[0]][15:8] = q_byte[0];
        else         mreg[q_idx[0]][7:0]  = q_byte[0];
        void'(q_due.pop_front());
        void'(q_idx.pop_front());
        void'(q_hi.pop_front());
        void'(q_byte.pop_front());
      end
      check("R2 register contents", reg_words, {mreg[3], mreg[2], mreg[1], mreg[0]});
      if (w_due.size() > 0 && w_due[0] == cyc) begin
        check("R9 write strobe", {bank_we, bank_addr, bank_byte}, {1'b1, w_addr[0], w_byte[0]});
        void'(w_due.pop_front());
        void'(w_addr.pop_front());
        void'(w_byte.pop_front());
      end else begin
        check("R9 strobe idle", {63'd0, bank_we}, 64'd0);
      end
      if (spi_cs_n) check("R8 miso idle", {63'd0, spi_miso}, 64'd0);
    end
  end

  // bmode: 0 none, 1 busy in mid frame, 2 busy in the commit cycle only
  task automatic frame(input logic [15:0] w, input int npulse, input int bmode, input string tag);
    logic [15:0] got;
    logic [15:0] want;
    int          c;
    int          idx;
    bit          mapped;
    bit          ok;
    got  = 16'h0000;
    want = exp_tx;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < npulse; b++) begin
      spi_sclk = 1'b0;
      spi_mosi = (b < 16) ? w[15-b] : 1'b0;
      if (bmode == 1 && b == 5) busy = 1'b1;
      repeat (HALF) @(negedge clk);
      if (b < 16) got[15-b] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (bmode == 1 && b == 8) busy = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    c = cyc;
    ok     = (npulse == 16) && (bmode == 0);
    idx    = int'(w[14:9]) - BASE;
    mapped = (idx >= 0) && (idx < NREG);
    if (ok && w[15]) begin
      w_due.push_back(c + 3);
      w_addr.push_back(w[14:8]);
      w_byte.push_back(w[7:0]);
      if (mapped) begin
        q_due.push_back(c + 4);
        q_idx.push_back(idx);
        q_hi.push_back(w[8]);
        q_byte.push_back(w[7:0]);
      end
      exp_tx = 16'h0000;
    end else if (ok) begin
      exp_tx = mapped ? mreg[idx] : 16'h0000;
    end else begin
      exp_tx = 16'h0000;
    end
    repeat (2) @(negedge clk);
    if (bmode == 2) busy = 1'b1;
    @(negedge clk);
    busy = 1'b0;
    repeat (5) @(negedge clk);
    if (npulse >= 16) check({tag, " readback"}, {48'd0, got}, {48'd0, want});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mreg[0] = 16'h0000;
    mreg[1] = 16'h0006;
    mreg[2] = 16'h001F;
    mreg[3] = 16'h0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    check("R1 reset defaults", reg_words, 64'h0000_001F_0006_0000);
    check("R1 strobe low", {63'd0, bank_we}, 64'd0);
    check("R1 miso low", {63'd0, spi_miso}, 64'd0);
    monitor_on = 1'b1;

    // R6 reads, even and odd addresses; R8 first response is zero
    frame(16'h4800, 16, 0, "R8 nothing armed");
    frame(16'h4600, 16, 0, "R6 sample period");
    frame(16'h4900, 16, 0, "R6 misc control");
    frame(16'hC807, 16, 0, "R6 odd address read");
    check("R2 low byte write", {48'd0, reg_words[47:32]}, 64'h0007);
    frame(16'hC912, 16, 0, "R8 after write");
    check("R2 high byte write", {48'd0, reg_words[47:32]}, 64'h1207);
    frame(16'hC4F0, 16, 0, "R2 gpio low byte");

    // R3 wrong clock counts
    frame(16'hC455, 15, 0, "R3 short frame");
    check("R3 short frame no write", {48'd0, reg_words[15:0]}, 64'h00F0);
    frame(16'hC455, 17, 0, "R3 long frame");
    check("R3 long frame no write", {48'd0, reg_words[15:0]}, 64'h00F0);
    frame(16'h4400, 16, 0, "R8 after dropped frame");

    // R4 suspension
    frame(16'hC6AA, 16, 1, "R4 busy mid frame");
    check("R4 busy mid frame no write", {48'd0, reg_words[31:16]}, 64'h0006);
    frame(16'hC7BB, 16, 2, "R4 busy at commit");
    check("R4 busy at commit no write", {48'd0, reg_words[31:16]}, 64'h0006);

    // R5 unmapped addresses
    frame(16'hA0FF, 16, 0, "R5 unmapped write");
    check("R5 unmapped write no effect", reg_words, 64'h0000_1207_0006_00F0);
    frame(16'h3000, 16, 0, "R5 unmapped read");
    frame(16'h4A00, 16, 0, "R5 unmapped returns zero");

    // R7 snapshot versus write in the response frame
    frame(16'h4400, 16, 0, "R7 arm gpio read");
    frame(16'hC4AB, 16, 0, "R7 old value during write");
    check("R7 write lands", {48'd0, reg_words[15:0]}, 64'h00AB);
    frame(16'h4500, 16, 0, "R7 arm again");
    frame(16'hCB01, 16, 0, "R7 new value");
    frame(16'h4A00, 16, 0, "R8 after command write");
    frame(16'h0000, 16, 0, "R6 command register");
    check("R2 command high byte", {48'd0, reg_words[63:48]}, 64'h0100);

    repeat (10) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule